// File: doc/BRIEF.md
# Table-Driven Decade Up/Down Counter

The block counts through the ten decimal digit values 0 to 9, upward or downward, one step per clock edge. Its next-state logic is a constant lookup table, not an adder: the table holds one 5-bit word for each of the 32 combinations of the 4-bit count and the direction bit. Each word gives the next count and a wrap flag. A 4-bit register loads the next-count half of the word on every rising edge. The wrap flag goes straight to the output as a carry when counting up and a borrow when counting down.

The table is computed when the design is elaborated, from the counter width and the modulus. It needs no memory initialisation file. Codes 10 to 15 cannot be reached in normal use, but they still have defined table words. Whatever gets the register into one of those codes, the counter returns to 0 on the next edge.

The block has one state per digit value, DIGIT_0 to DIGIT_9. Under the up direction each DIGIT_n moves to DIGIT_n+1, and DIGIT_9 moves to DIGIT_0 with the wrap flag raised. Under the down direction each DIGIT_n moves to DIGIT_n-1, and DIGIT_0 moves to DIGIT_9 with the wrap flag raised. Every unused code moves to DIGIT_0 with the flag low. Reset moves any state to DIGIT_0.

Top module: `updn_decade_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is 0 after that edge, whatever `dir` is and whatever the count was.
- R2: With `dir` = 0 (up) and `count` between 0 and 8, `count` increases by one at the next edge.
- R3: With `dir` = 0 and `count` = 9, `carry` is 1 during that cycle and `count` becomes 0 at the next edge.
- R4: With `dir` = 1 (down) and `count` between 1 and 9, `count` decreases by one at the next edge.
- R5: With `dir` = 1 and `count` = 0, `carry` is 1 during that cycle and `count` becomes 9 at the next edge.
- R6: In every other combination of a legal count and `dir`, `carry` is 0.
- R7: For the unused codes 10 to 15, in either direction, the table word has next count 0 and flag 0.
- R8: `carry` follows `dir` within the same cycle, with no clock edge needed. A change of `dir` changes the count direction starting at the next edge.
- R9: The table is addressed by {dir, count}, with `dir` as address bit 4 and the count as bits 3..0. Its word is {flag, next}, with the flag as bit 4 and the next count as bits 3..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Count direction: 0 counts up, 1 counts down |
| count | output | 4 | Current digit value |
| carry | output | 1 | Wrap flag: carry when counting up, borrow when counting down |

## Verification
The `carry` output is due in the same cycle as the count and `dir` that produce it. The bench compares it 1 ns before the next rising edge, once `dir` has settled since the falling edge. The new `count` and the effect of reset are due one edge after the stimulus, and the bench compares them 1 ns after that edge. A scoreboard entry pairs each driven cycle with both of these due points. The unused codes cannot be reached through the ports. The bench therefore reads all 32 table words from a separate instance of the table module, applying each address and checking the word after 1 ns.

// File: rtl/updn_decade_pkg.sv
package updn_decade_pkg;

    localparam int unsigned DEF_CNT_W   = 4;
    localparam int unsigned DEF_MODULUS = 10;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;

endpackage

// File: rtl/updn_rom_table.sv
module updn_rom_table
    import updn_decade_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned MODULUS = DEF_MODULUS
) (
    input  logic [CNT_W:0] addr,
    output logic [CNT_W:0] word
);
    localparam int unsigned AW    = CNT_W + 1;
    localparam int unsigned DW    = CNT_W + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned SPAN  = 1 << CNT_W;

    // Builds the word for one address: {flag, next count}
    function automatic logic [DW-1:0] word_of(input int unsigned a);
        int unsigned q;
        count_dir_e  d;
        logic [DW-1:0] w;
        q = a % SPAN;
        d = (a >= SPAN) ? DIR_DOWN : DIR_UP;
        w = '0;
        if (q < MODULUS) begin
            unique case (d)
                DIR_UP: begin
                    if (q == MODULUS - 1) w = {1'b1, {CNT_W{1'b0}}};
                    else                  w = {1'b0, CNT_W'(q + 1)};
                end
                DIR_DOWN: begin
                    if (q == 0) w = {1'b1, CNT_W'(MODULUS - 1)};
                    else        w = {1'b0, CNT_W'(q - 1)};
                end
            endcase
        end
        return w;
    endfunction

    logic [DW-1:0] rom_q [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        localparam logic [DW-1:0] W_CONST = word_of(a);
        assign rom_q[a] = W_CONST;
    end

    assign word = rom_q[addr];

endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/updn_decade_counter.sv
module updn_decade_counter
    import updn_decade_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned MODULUS = DEF_MODULUS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir,
    output logic [CNT_W-1:0] count,
    output logic             carry
);
    localparam int unsigned AW = CNT_W + 1;

    logic [AW-1:0]    rom_addr;
    logic [CNT_W:0]   rom_word;
    logic [CNT_W-1:0] next_count;
    logic [CNT_W-1:0] state_q;

    assign rom_addr = {dir, state_q};

    updn_rom_table #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_table (
        .addr (rom_addr),
        .word (rom_word)
    );

    assign next_count = rom_word[CNT_W-1:0];

    updn_state_reg #(.W(CNT_W)) u_state (
        .clk (clk),
        .rst (rst),
        .d   (next_count),
        .q   (state_q)
    );

    always_comb begin
        count = state_q;
        carry = rom_word[CNT_W];
    end

endmodule

// File: rtl/updn_decade_counter_chk.sv
module updn_decade_counter_chk #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned MODULUS = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             dir,
    input logic [CNT_W-1:0] count,
    input logic             carry
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MODULUS - 1);

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> count == '0);

    a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
        (!dir && count < TOP) |=> count == $past(count) + 1'b1);

    a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!dir && count == TOP) |-> carry ##1 count == '0);

    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (dir && count != '0 && count <= TOP) |=> count == $past(count) - 1'b1);

    a_r5_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (dir && count == '0) |-> carry ##1 count == TOP);

    a_r6_carry_quiet: assert property (@(posedge clk) disable iff (rst)
        (count <= TOP && !(dir == 1'b0 && count == TOP) && !(dir && count == '0)) |-> !carry);

    a_r7_unused_recover: assert property (@(posedge clk) disable iff (rst)
        (count > TOP) |-> !carry ##1 count == '0);
endmodule

bind updn_decade_counter updn_decade_counter_chk #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_chk (.*);

// File: tb/updn_decade_counter_tb.sv
module updn_decade_counter_tb;
    localparam int CW  = 4;
    localparam int MOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dir = 1'b0;
    logic [CW-1:0] count;
    logic          carry;
    logic [CW:0]   tbl_addr = '0;
    logic [CW:0]   tbl_word;

    always #5 clk = ~clk;

    updn_decade_counter #(.CNT_W(CW), .MODULUS(MOD)) u_dut (
        .clk(clk), .rst(rst), .dir(dir), .count(count), .carry(carry)
    );

    updn_rom_table #(.CNT_W(CW), .MODULUS(MOD)) u_tbl (
        .addr(tbl_addr), .word(tbl_word)
    );

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit model_valid = 0;
    bit done = 0;

    logic [CW:0] exp_q[$];
    string       tag_q[$];
    string       ctag_q[$];
    bit          cval_q[$];

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected results
    task automatic step(input logic r, input logic d, input string ovr);
        int nxt;
        bit  c;
        string t, ct;
        @(negedge clk);
        rst = r;
        dir = d;
        c  = 0;
        ct = "R6";
        if (!d && model == MOD - 1)      begin c = 1; ct = "R3"; end
        else if (d && model == 0)        begin c = 1; ct = "R5"; end
        if (r) begin nxt = 0; t = "R1"; end
        else if (!d) begin
            if (model == MOD - 1) begin nxt = 0; t = "R3"; end
            else begin nxt = model + 1; t = "R2"; end
        end else begin
            if (model == 0) begin nxt = MOD - 1; t = "R5"; end
            else begin nxt = model - 1; t = "R4"; end
        end
        if (ovr.len() > 0) begin t = ovr; ct = ovr; end
        exp_q.push_back({c, CW'(nxt)});
        tag_q.push_back(t);
        ctag_q.push_back(ct);
        cval_q.push_back(model_valid);
        model = nxt;
        model_valid = 1;
    endtask

    // Monitor: carry just before the edge, count just after it
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                logic [CW:0] e;
                string t, ct;
                bit cv;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                ct = ctag_q.pop_front();
                cv = cval_q.pop_front();
                if (cv) check(ct, "carry", int'(carry), int'(e[CW]));
                @(posedge clk);
                #1;
                check(t, "count", int'(count), int'(e[CW-1:0]));
            end
        end
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(1, 0, "");
        step(1, 1, "");
        for (int i = 0; i < 23; i++) step(0, 0, "");
        for (int i = 0; i < 23; i++) step(0, 1, "");
        for (int i = 0; i < 8; i++)  step(0, logic'(i % 2), "");
        step(1, 0, "");
        for (int i = 0; i < 7; i++)  step(0, 0, "");
        step(1, 1, "");
        // R8: direction flips at count 0 and 9; carry tracks dir within the cycle
        step(0, 1, "R8");
        step(0, 0, "R8");
        step(0, 1, "R8");
        step(0, 0, "R8");
        step(0, 0, "R8");
        step(0, 1, "R8");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;

        // R7 and R9: full table sweep through the standalone table instance
        for (int a = 0; a < 32; a++) begin
            int q, ew;
            bit d;
            q = a % 16;
            d = (a >= 16);
            if (q >= MOD)              ew = 0;
            else if (!d && q == MOD-1) ew = 16;
            else if (!d)               ew = q + 1;
            else if (q == 0)           ew = 16 + MOD - 1;
            else                       ew = q - 1;
            tbl_addr = 5'(a);
            #1;
            if (q >= MOD) check("R7", $sformatf("word[%0d]", a), int'(tbl_word), ew);
            else          check("R9", $sformatf("word[%0d]", a), int'(tbl_word), ew);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule